// File: doc/BRIEF.md
# Countdown Timer with Register Bus and Interrupt

This block is a down-counting timer that software drives through a small word-wide register bus. Software loads a reload value into the period register and then sets the run bit in the control register. While the run bit is set, each cycle on which the tick-enable input is high moves the live count one step toward zero. When the count is zero on such a tick, and the interrupt-enable bit is set, the count is reloaded from the period register. On that same tick an interrupt event is raised. It is latched into a sticky status flag and also appears as a one-cycle pulse on the interrupt output.

The bus carries one request per cycle, and every request gets a registered response on the following cycle. The response carries read data or an error flag. Four word registers are decoded: status, control, period and a read-only view of the live count. Any access that is not a legal full-word access to one of them is rejected and changes nothing.

Top module: `cdtimer_top`

## Requirements
- R1: After reset, status, control, period and the live count all read as zero, and irq is low.
- R2: Registers sit at byte offsets status 0x0, control 0x4, period 0x8 and count 0xC. A legal word write to status, control or period reads back unchanged. Each request (req_valid high) yields resp_valid high on the next cycle, and that response carries the read data.
- R3: While control bit 2 (run) is set, each cycle with tick_en high and a nonzero count lowers the count by exactly one. Without tick_en, or with run clear, the count holds.
- R4: On a running tick where the count is zero, the count loads the period value if control bit 0 (interrupt enable) is set. If that bit is clear, the count stays at zero.
- R5: On a running tick with a zero count and control bit 0 set, irq is high during the following cycle only, unless the next tick meets the condition again.
- R6: The same event sets status bit 0, which stays set until software writes status. A status write loads the written word, but an event in the same cycle forces bit 0 to one.
- R7: A write to offset 0xC responds with resp_err high and changes no register.
- R8: An access whose req_size is not 2 (word; 0 is byte, 1 is half), whose address is not a multiple of four, or whose address is above 0xC responds with resp_err high. It changes no register and returns resp_rdata zero. A legal access responds with resp_err low.
- R9: A tick in the same cycle as a control write acts on the control value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle count enable |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_err | output | 1 | Previous request was illegal |
| resp_rdata | output | DATA_W | Read data, zero on error or write |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A request made in cycle N is answered in cycle N+1. Read data shows register contents as they stood in cycle N, before that edge's own updates. A tick in cycle N changes the count, the status flag and irq, and all three are visible from cycle N+1. The bench therefore drives inputs shortly after the falling edge. It advances a behavioural model at the rising edge using the same input values. At the next falling edge it compares the design's outputs with the model's, so each result is compared in exactly the cycle it is due.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned NUM_REGS    = 4;
  localparam int unsigned IDX_STATUS  = 0;
  localparam int unsigned IDX_CONTROL = 1;
  localparam int unsigned IDX_PERIOD  = 2;
  localparam int unsigned IDX_COUNT   = 3;

  localparam int unsigned CTRL_IE_BIT  = 0;
  localparam int unsigned CTRL_RUN_BIT = 2;
  localparam int unsigned STAT_EVT_BIT = 0;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;
endpackage

// File: rtl/cdt_regdec.sv
module cdt_regdec
  import cdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  output logic [NUM_REGS-1:0] sel,
  output logic                acc_ok,
  output logic                acc_err,
  output logic                wr_en
);
  localparam int unsigned IDX_LSB = 2;

  logic [1:0] idx;
  logic       in_range;
  logic       aligned;
  logic       word_sz;
  logic       ro_hit;

  always_comb begin
    idx      = req_addr[IDX_LSB +: 2];
    in_range = ((req_addr >> (IDX_LSB + 2)) == '0);
    aligned  = (req_addr[IDX_LSB-1:0] == '0);
    word_sz  = (req_size == SZ_WORD);
    ro_hit   = req_write && (idx == 2'(IDX_COUNT));
    acc_ok   = req_valid && in_range && aligned && word_sz && !ro_hit;
    acc_err  = req_valid && !acc_ok;
    wr_en    = acc_ok && req_write;
    sel      = acc_ok ? (NUM_REGS'(1) << idx) : '0;
  end
endmodule

// File: rtl/cdt_regfile.sv
module cdt_regfile
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NUM_REGS-1:0] sel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                fire,
  output logic [DATA_W-1:0]   status_o,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [DATA_W-1:0]   period_o
);
  localparam int unsigned NUM_RW = NUM_REGS - 1;

  logic [DATA_W-1:0] regs [NUM_RW];

  for (genvar i = 0; i < NUM_RW; i++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else begin
        if (wr_en && sel[i]) regs[i] <= wdata;
        if ((i == IDX_STATUS) && fire) regs[i][STAT_EVT_BIT] <= 1'b1;
      end
    end
  end

  assign status_o = regs[IDX_STATUS];
  assign ctrl_o   = regs[IDX_CONTROL];
  assign period_o = regs[IDX_PERIOD];

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    fire |=> status_o[STAT_EVT_BIT]); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status_o[STAT_EVT_BIT] && !(wr_en && sel[IDX_STATUS])) |=> status_o[STAT_EVT_BIT]); // R6
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              ie,
  input  logic [DATA_W-1:0] period,
  output logic [DATA_W-1:0] count_o,
  output logic              fire_o,
  output logic              irq_o
);
  logic step;
  logic at_zero;

  always_comb begin
    step    = tick && run;
    at_zero = (count_o == '0);
    fire_o  = step && at_zero && ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= fire_o;
      if (step) begin
        if (!at_zero)  count_o <= count_o - 1'b1;
        else if (ie)   count_o <= period;
      end
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && run && count_o != '0) |=> (count_o == $past(count_o) - 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(tick && run) |=> $stable(count_o)); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && run && ie && count_o == '0) |=> (count_o == $past(period))); // R4
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(tick && run && ie && count_o == '0)); // R5
endmodule

// File: rtl/cdtimer_top.sv
module cdtimer_top
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              irq
);
  logic [NUM_REGS-1:0] sel;
  logic                acc_ok, acc_err, wr_en, fire;
  logic [DATA_W-1:0]   status_q, ctrl_q, period_q, count_q;
  logic [DATA_W-1:0]   rd_mux;

  cdt_regdec #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .sel(sel), .acc_ok(acc_ok), .acc_err(acc_err),
    .wr_en(wr_en)
  );

  cdt_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(req_wdata),
    .fire(fire), .status_o(status_q), .ctrl_o(ctrl_q), .period_o(period_q)
  );

  cdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .run(ctrl_q[CTRL_RUN_BIT]),
    .ie(ctrl_q[CTRL_IE_BIT]), .period(period_q), .count_o(count_q),
    .fire_o(fire), .irq_o(irq)
  );

  always_comb begin
    rd_mux = '0;
    if (acc_ok && !req_write) begin
      unique case (1'b1)
        sel[IDX_STATUS]:  rd_mux = status_q;
        sel[IDX_CONTROL]: rd_mux = ctrl_q;
        sel[IDX_PERIOD]:  rd_mux = period_q;
        sel[IDX_COUNT]:   rd_mux = count_q;
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= acc_err;
      resp_rdata <= rd_mux;
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R2
  AST_ERR_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_err) |-> ($stable(period_q) && $stable(ctrl_q))); // R7
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (resp_rdata == '0)); // R8
endmodule

// File: tb/tb_cdtimer_top.sv
module tb_cdtimer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        resp_valid, resp_err, irq;
  logic [31:0] resp_rdata;

  cdtimer_top #(.DATA_W(32), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_rdata(resp_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    n_cyc = 0;
  bit    cmp_on = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference state
  logic [31:0] m_stat = 0, m_ctrl = 0, m_per = 0, m_cnt = 0, m_rdata = 0;
  logic        m_irq = 0, m_rv = 0, m_err = 0;

  always @(posedge clk) begin
    logic        legal, fire;
    logic [31:0] nxt_cnt, rd;
    if (rst) begin
      m_stat = 0; m_ctrl = 0; m_per = 0; m_cnt = 0;
      m_irq = 0; m_rv = 0; m_err = 0; m_rdata = 0;
    end else begin
      legal = req_valid && req_size == 2'd2 && req_addr[1:0] == 2'b00 &&
              req_addr <= 8'hC && !(req_write && req_addr == 8'hC);
      fire  = tick_en && m_ctrl[2] && m_cnt == 0 && m_ctrl[0];
      nxt_cnt = m_cnt;
      if (tick_en && m_ctrl[2]) begin
        if (m_cnt != 0) nxt_cnt = m_cnt - 1;
        else if (m_ctrl[0]) nxt_cnt = m_per;
      end
      rd = 0;
      if (legal && !req_write) begin
        case (req_addr[3:2])
          2'd0: rd = m_stat;
          2'd1: rd = m_ctrl;
          2'd2: rd = m_per;
          default: rd = m_cnt;
        endcase
      end
      if (legal && req_write) begin
        case (req_addr[3:2])
          2'd0: m_stat = req_wdata;
          2'd1: m_ctrl = req_wdata;
          2'd2: m_per  = req_wdata;
          default: ;
        endcase
      end
      if (fire) m_stat[0] = 1'b1;
      m_cnt   = nxt_cnt;
      m_irq   = fire;
      m_rv    = req_valid;
      m_err   = req_valid && !legal;
      m_rdata = rd;
    end
  end

  task automatic check(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check(tag, "irq", 32'(irq), 32'(m_irq));
      check(tag, "resp_valid", 32'(resp_valid), 32'(m_rv));
      if (m_rv) begin
        check(tag, "resp_err", 32'(resp_err), 32'(m_err));
        check(tag, "resp_rdata", resp_rdata, m_rdata);
      end
    end
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic drive(input logic v, input logic w, input logic [7:0] a,
                       input logic [1:0] s, input logic [31:0] d, input logic t);
    @(negedge clk);
    #2;
    req_valid = v; req_write = w; req_addr = a; req_size = s;
    req_wdata = d; tick_en = t;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t = 0);
    drive(1, 1, a, 2'd2, d, t);
  endtask
  task automatic rd(input logic [7:0] a, input logic t = 0);
    drive(1, 0, a, 2'd2, 0, t);
  endtask
  task automatic idle(input logic t = 0);
    drive(0, 0, 0, 2'd2, 0, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst = 0;
    cmp_on = 1;
    // R1: reset state
    tag = "R1";
    check("R1", "irq_at_reset", 32'(irq), 0);
    rd(8'h0); rd(8'h4); rd(8'h8); rd(8'hC); idle();
    // R2: read-back of writable registers
    tag = "R2";
    wr(8'h0, 32'hA5A5_0F0E); wr(8'h8, 32'd5); wr(8'h4, 32'h0000_0102);
    rd(8'h0); rd(8'h4); rd(8'h8); wr(8'h0, 0); wr(8'h4, 0); idle();
    // R4: running, interrupt enable clear -> count stays zero
    tag = "R4";
    wr(8'h4, 32'h4);
    for (int i = 0; i < 4; i++) rd(8'hC, 1);
    // R5: enable interrupt -> reload and pulse
    tag = "R5";
    wr(8'h4, 32'h5);
    idle(1); rd(8'hC); idle(); rd(8'h0);
    // R3: countdown with gaps and with run cleared
    tag = "R3";
    for (int i = 0; i < 12; i++) rd(8'hC, (i % 3) != 1);
    wr(8'h4, 32'h1);
    for (int i = 0; i < 4; i++) rd(8'hC, 1);
    wr(8'h4, 32'h5);
    for (int i = 0; i < 8; i++) rd(8'hC, 1);
    // R6: sticky flag and write racing an event
    tag = "R6";
    wr(8'h8, 0); idle(1); idle(1);
    wr(8'h0, 0, 1); rd(8'h0); wr(8'h0, 0); rd(8'h0);
    wr(8'h4, 0, 1); wr(8'h0, 32'h10); rd(8'h0);
    // R9: tick acts on previous control value
    tag = "R9";
    wr(8'h8, 3); wr(8'h4, 32'h5); idle(1); idle(1);
    wr(8'h4, 0, 1); rd(8'hC, 1); wr(8'h4, 32'h4, 1); rd(8'hC, 1); rd(8'hC);
    // R7: write to count is rejected
    tag = "R7";
    wr(8'hC, 32'hDEAD_BEEF); rd(8'hC); rd(8'h8); rd(8'h4);
    // R8: bad size, misaligned, out of range
    tag = "R8";
    drive(1, 1, 8'h8, 2'd0, 32'h77, 0);
    drive(1, 1, 8'h8, 2'd1, 32'h77, 0);
    drive(1, 1, 8'h8, 2'd3, 32'h77, 0);
    drive(1, 0, 8'h4, 2'd0, 0, 0);
    wr(8'h6, 32'h99); wr(8'h10, 32'h99); rd(8'h14); rd(8'h41);
    rd(8'h8); rd(8'h4); rd(8'h0);
    // R9: mixed traffic against the model
    tag = "R9";
    for (int i = 0; i < 3000; i++) begin
      int unsigned k = $urandom_range(0, 9);
      logic t = ($urandom_range(0, 2) != 0);
      case (k)
        0: wr(8'h4, 32'($urandom_range(0, 7)), t);
        1: wr(8'h8, 32'($urandom_range(0, 4)), t);
        2: wr(8'h0, 32'($urandom_range(0, 3)), t);
        3: rd(8'h0, t);
        4: rd(8'hC, t);
        5: wr(8'hC, 32'h5, t);
        6: drive(1, 1, 8'h4, 2'($urandom_range(0, 3)), 32'h5, t);
        7: rd(8'($urandom_range(0, 31)), t);
        default: idle(t);
      endcase
    end
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule